// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block folds a large set of level-sensitive interrupt sources into one parent line per group. Every group gathers eight sources, and four groups are packed as the byte lanes of a 32-bit register bank. Each group line is high while at least one of its sources is both asserted and enabled. The default build has 20 groups, which gives 160 sources in five banks.

Software works through a 32-bit register bus with an address, a write strobe, write data and read data. Each bank has four word slots in a 16-byte window. One slot turns enable bits on, one turns them off, and one reports the enabled pending sources. Because enable bits are only ever set or cleared, no read-modify-write is needed to change one source. The set slot reads back the whole enable word, so software can save that word and write it back later.

Top module: `irq_combiner_top`

## Requirements
- R1: While reset is low and on the cycle after it is released, every enable bit is 0, every `grp_irq` bit is 0 and `reg_rdata` is 0, whatever the sources do.
- R2: Bank b occupies byte addresses b*16 to b*16+15 and is selected by `reg_addr[7:4]`. The word slot is selected by `reg_addr[3:2]`, and `reg_addr[1:0]` is ignored. Group g uses bits [8*(g%4)+7 : 8*(g%4)] of bank g/4, and source i of the whole block is bit i%32 of bank i/32.
- R3: A write to slot 0 (byte offset 0x0) sets each enable bit of the bank whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A write to slot 1 (byte offset 0x4) clears each enable bit of the bank whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R5: A read of slot 0 returns the bank's 32 enable bits. Read data is registered: `reg_rdata` shows the word for the address that was present at a clock edge from that edge until the next edge.
- R6: A read of slot 3 (byte offset 0xC) returns, for each of the bank's 32 sources, the source input captured at the previous clock edge ANDed with its enable bit.
- R7: `grp_irq[g]` is the OR over the group's eight bits of (captured input AND enable). It follows a change of the inputs one clock edge later and stays high for as long as an enabled input stays high.
- R8: Writes to slot 2 (0x8), to slot 3 (0xC) and to banks above the last one change no enable bit. Reads of slot 1, of slot 2 and of banks above the last one return 0.
- R9: When a set and a clear of the same bit arrive in consecutive writes, the later write decides the bit's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 160 | Level-sensitive interrupt sources, source i in bank i/32 |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| grp_irq | output | 20 | One parent interrupt line per group |

## Verification
The hardest case to reach from the ports is a group in the last bank whose byte lane sits in the top of the word. Reaching it needs an address with nonzero low bits, a set write in the upper lane, and a source near the top of the input vector. The stimulus does that write, drives source 159, checks `grp_irq[19]` edge by edge as the source falls, and leaves the lower group of the same bank unchanged. A walk over every group, one source at a time, then shows that no group borrows a lane from a neighbouring bank.

// File: rtl/comb_pkg.sv
package comb_pkg;

    localparam int unsigned LANE_W         = 8;
    localparam int unsigned LANES_PER_BANK = 4;
    localparam int unsigned WORD_W         = LANE_W * LANES_PER_BANK;
    localparam int unsigned BANK_SPAN_LOG2 = 4;

    // word slot within one bank window, selected by address bits [3:2]
    typedef enum logic [1:0] {
        SLOT_EN_SET = 2'd0,
        SLOT_EN_CLR = 2'd1,
        SLOT_SPARE  = 2'd2,
        SLOT_STATUS = 2'd3
    } slot_e;

    // bits of a bank word that belong to lanes actually present
    function automatic logic [WORD_W-1:0] lane_mask(input int unsigned lanes);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int l = 0; l < int'(LANES_PER_BANK); l++) begin
            if (l < int'(lanes)) begin
                m[l*LANE_W +: LANE_W] = {LANE_W{1'b1}};
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/comb_addr_dec.sv
module comb_addr_dec
    import comb_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output slot_e                slot
);

    localparam int unsigned BIDX_W = ADDR_W - BANK_SPAN_LOG2;

    logic [BIDX_W-1:0] bank_idx;
    logic [1:0]        unused_byte_lsb;

    assign bank_idx        = addr[ADDR_W-1:BANK_SPAN_LOG2];
    assign slot            = slot_e'(addr[3:2]);
    assign unused_byte_lsb = addr[1:0];

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_hit
        assign bank_hit[b] = (bank_idx == BIDX_W'(b));
    end

endmodule

// File: rtl/comb_capture.sv
module comb_capture #(
    parameter int unsigned WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] pend
);

    typedef struct packed {
        logic [WIDTH-1:0] pend;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.pend = src;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign pend = cap_q.pend;

endmodule

// File: rtl/comb_bank.sv
module comb_bank
    import comb_pkg::*;
#(
    parameter int unsigned LANES_VALID = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hit,
    input  logic                      we,
    input  slot_e                     slot,
    input  logic [WORD_W-1:0]         wdata,
    input  logic [WORD_W-1:0]         pend,
    output logic [WORD_W-1:0]         en,
    output logic [WORD_W-1:0]         status,
    output logic [LANES_PER_BANK-1:0] lane_irq
);

    localparam logic [WORD_W-1:0] VALID_MASK = lane_mask(LANES_VALID);

    typedef struct packed {
        logic [WORD_W-1:0] en;
    } bank_state_t;

    bank_state_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (hit && we) begin
            unique case (slot)
                SLOT_EN_SET: bank_d.en = (bank_q.en | wdata) & VALID_MASK;
                SLOT_EN_CLR: bank_d.en = bank_q.en & ~wdata;
                default:     bank_d.en = bank_q.en;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign en     = bank_q.en;
    assign status = pend & bank_q.en;

    for (genvar l = 0; l < int'(LANES_PER_BANK); l++) begin : g_lane
        assign lane_irq[l] = |status[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/irq_combiner_top.sv
module irq_combiner_top
    import comb_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 20,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*LANE_W-1:0] irq_in,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic                         reg_we,
    input  logic [WORD_W-1:0]            reg_wdata,
    output logic [WORD_W-1:0]            reg_rdata,
    output logic [NUM_GROUPS-1:0]        grp_irq
);

    localparam int unsigned NUM_SRC   = NUM_GROUPS * LANE_W;
    localparam int unsigned NUM_BANKS = (NUM_GROUPS + LANES_PER_BANK - 1) / LANES_PER_BANK;
    localparam int unsigned PAD_SRC   = NUM_BANKS * WORD_W;
    localparam int unsigned PAD_GRP   = NUM_BANKS * LANES_PER_BANK;

    logic [NUM_SRC-1:0]   pend;
    logic [PAD_SRC-1:0]   pend_pad;
    logic [PAD_SRC-1:0]   en_all;
    logic [PAD_SRC-1:0]   stat_all;
    logic [PAD_GRP-1:0]   grp_pad;
    logic [NUM_BANKS-1:0] bank_hit;
    slot_e                slot;

    comb_addr_dec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) i_dec (
        .addr     (reg_addr),
        .bank_hit (bank_hit),
        .slot     (slot)
    );

    comb_capture #(
        .WIDTH (NUM_SRC)
    ) i_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (irq_in),
        .pend  (pend)
    );

    always_comb begin
        pend_pad              = '0;
        pend_pad[NUM_SRC-1:0] = pend;
    end

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
        localparam int unsigned LEFT  = NUM_GROUPS - b * LANES_PER_BANK;
        localparam int unsigned LANES = (LEFT > LANES_PER_BANK) ? LANES_PER_BANK : LEFT;

        comb_bank #(
            .LANES_VALID (LANES)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (bank_hit[b]),
            .we       (reg_we),
            .slot     (slot),
            .wdata    (reg_wdata),
            .pend     (pend_pad[b*WORD_W +: WORD_W]),
            .en       (en_all[b*WORD_W +: WORD_W]),
            .status   (stat_all[b*WORD_W +: WORD_W]),
            .lane_irq (grp_pad[b*LANES_PER_BANK +: LANES_PER_BANK])
        );
    end

    assign grp_irq = grp_pad[NUM_GROUPS-1:0];

    logic unused_pad_grp;
    assign unused_pad_grp = ^grp_pad;

    // registered read path
    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.rdata = '0;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (bank_hit[b]) begin
                unique case (slot)
                    SLOT_EN_SET: rd_d.rdata = en_all[b*WORD_W +: WORD_W];
                    SLOT_STATUS: rd_d.rdata = stat_all[b*WORD_W +: WORD_W];
                    default:     rd_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata = rd_q.rdata;

endmodule

// File: rtl/comb_checker.sv
module comb_checker
    import comb_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 20,
    parameter int unsigned ADDR_W     = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [NUM_GROUPS*LANE_W-1:0]        irq_in,
    input logic [ADDR_W-1:0]                   reg_addr,
    input logic                                reg_we,
    input logic [WORD_W-1:0]                   reg_wdata,
    input logic [WORD_W-1:0]                   reg_rdata,
    input logic [NUM_GROUPS-1:0]               grp_irq,
    input logic [((NUM_GROUPS+3)/4)*WORD_W-1:0] en_all
);

    localparam int unsigned NUM_BANKS = (NUM_GROUPS + LANES_PER_BANK - 1) / LANES_PER_BANK;
    localparam int unsigned BIDX_W    = ADDR_W - BANK_SPAN_LOG2;

    logic [BIDX_W-1:0] bidx;
    logic              bank_ok;
    assign bidx    = reg_addr[ADDR_W-1:BANK_SPAN_LOG2];
    assign bank_ok = (int'(bidx) < int'(NUM_BANKS));

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_all == '0) && (grp_irq == '0) && (reg_rdata == '0));

    a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr[3] || !bank_ok)) |=> $stable(en_all));

    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr[3:2] == 2'd1) || (reg_addr[3:2] == 2'd2) || !bank_ok) |=> (reg_rdata == '0));

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bk
        localparam int unsigned LEFT  = NUM_GROUPS - b * LANES_PER_BANK;
        localparam int unsigned LANES = (LEFT > LANES_PER_BANK) ? LANES_PER_BANK : LEFT;
        localparam logic [WORD_W-1:0] MSK = lane_mask(LANES);

        a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && bidx == BIDX_W'(b) && reg_addr[3:2] == 2'd0) |=>
            ((en_all[b*WORD_W +: WORD_W] & $past(reg_wdata & MSK)) == $past(reg_wdata & MSK)));

        a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && bidx == BIDX_W'(b) && reg_addr[3:2] == 2'd1) |=>
            ((en_all[b*WORD_W +: WORD_W] & $past(reg_wdata)) == '0));

        a_r5_enable_readback: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_we && bidx == BIDX_W'(b) && reg_addr[3:2] == 2'd0) |=>
            (reg_rdata == $past(en_all[b*WORD_W +: WORD_W])));
    end

    for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_grp
        a_r7_group_level: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] == |($past(irq_in[g*LANE_W +: LANE_W]) & en_all[g*LANE_W +: LANE_W]));
    end

endmodule

bind irq_combiner_top comb_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) i_comb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .grp_irq   (grp_irq),
    .en_all    (en_all)
);

// File: tb/test_irq_combiner_top.sv
module test_irq_combiner_top;

    localparam int NG = 20;
    localparam int NS = NG * 8;
    localparam int NB = 5;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NG-1:0] grp_irq;

    always #5 clk = ~clk;

    irq_combiner_top #(.NUM_GROUPS(NG), .ADDR_W(AW)) i_irq_combiner_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp_irq(grp_irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [NS-1:0] en_m = '0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [31:0] exp;
        string       tag;
        int          due;
        logic [7:0]  addr;
    } rd_item_t;

    rd_item_t sb_q[$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int b;
        b = int'(a[7:4]);
        if (b >= NB) return '0;
        case (a[3:2])
            2'd0:    return en_m[b*32 +: 32];
            2'd3:    return irq_in[b*32 +: 32] & en_m[b*32 +: 32];
            default: return '0;
        endcase
    endfunction

    function automatic logic [NG-1:0] model_grp();
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++) r[g] = |(irq_in[g*8 +: 8] & en_m[g*8 +: 8]);
        return r;
    endfunction

    // driver: one register write, model updated after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int b;
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        b = int'(a[7:4]);
        if (b < NB) begin
            if (a[3:2] == 2'd0) en_m[b*32 +: 32] = en_m[b*32 +: 32] | d;
            if (a[3:2] == 2'd1) en_m[b*32 +: 32] = en_m[b*32 +: 32] & ~d;
        end
    endtask

    // driver: read request, expected value pushed to the scoreboard
    task automatic rd(input logic [7:0] a, input string tag);
        rd_item_t it;
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        it.exp = model_read(a); it.tag = tag; it.due = cyc + 1; it.addr = a;
        sb_q.push_back(it);
    endtask

    // monitor: compares each read one edge after its address was presented
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            rd_item_t it;
            it = sb_q.pop_front();
            check($sformatf("%s read @%0h", it.tag, it.addr), 64'(reg_rdata), 64'(it.exp));
        end
    end

    task automatic set_irq(input logic [NS-1:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [NG-1:0] held;
        // R1: reset with all sources high
        irq_in = '1;
        repeat (4) @(negedge clk);
        check("R1 grp in reset", 64'(grp_irq), 64'(0));
        check("R1 rdata in reset", 64'(reg_rdata), 64'(0));
        rst_n = 1'b1;
        check("R1 grp after release", 64'(grp_irq), 64'(0));
        rd(8'h00, "R1");
        rd(8'h40, "R1");
        set_irq('0);
        drain();

        // R3 / R5: set and read back
        wr(8'h00, 32'h0000_00A5);
        rd(8'h00, "R3 R5");
        wr(8'h00, 32'h00FF_0000);
        rd(8'h00, "R3 keep");
        // R4: clear part
        wr(8'h04, 32'h0000_0005);
        rd(8'h00, "R4");
        drain();

        // R6 / R7: status and group lines
        begin
            logic [NS-1:0] v;
            v = '0;
            v[7:0] = 8'h81; v[15:8] = 8'hFF; v[39:32] = 8'h01;
            set_irq(v);
        end
        check("R7 groups pattern A", 64'(grp_irq), 64'(model_grp()));
        check("R7 group0 high", 64'(grp_irq[0]), 64'(1));
        check("R7 group1 masked", 64'(grp_irq[1]), 64'(0));
        rd(8'h0C, "R6");
        rd(8'h1C, "R6 bank1 none enabled");
        drain();

        // R2: last bank, top lane, low address bits ignored
        wr(8'h41, 32'hFF00_0000);
        rd(8'h40, "R2");
        begin
            logic [NS-1:0] v;
            v = irq_in; v[159] = 1'b1; v[127] = 1'b1;
            set_irq(v);
        end
        check("R2 group19 high", 64'(grp_irq[19]), 64'(1));
        check("R2 group15 masked", 64'(grp_irq[15]), 64'(0));
        check("R2 group16 untouched", 64'(grp_irq[16]), 64'(0));
        rd(8'h4C, "R6 bank4");
        drain();

        // R7: level hold and one-edge latency on release
        repeat (4) begin
            @(negedge clk);
            check("R7 held level", 64'(grp_irq[19]), 64'(1));
        end
        @(negedge clk);
        irq_in[159] = 1'b0;
        check("R7 before edge", 64'(grp_irq[19]), 64'(1));
        @(negedge clk);
        check("R7 after edge", 64'(grp_irq[19]), 64'(0));

        // R8: ignored writes and zero reads
        held = grp_irq;
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'hF0, 32'hFFFF_FFFF);
        for (int b = 0; b < NB; b++) rd(8'(b * 16), "R8 enables unchanged");
        rd(8'h04, "R8 clear slot reads zero");
        rd(8'h08, "R8 spare slot reads zero");
        rd(8'h50, "R8 missing bank reads zero");
        rd(8'h5C, "R8 missing bank status zero");
        drain();
        check("R8 groups unchanged", 64'(grp_irq), 64'(held));

        // R9: later write wins
        wr(8'h20, 32'h0000_0001);
        wr(8'h24, 32'h0000_0001);
        rd(8'h20, "R9 set then clear");
        wr(8'h24, 32'h0000_0002);
        wr(8'h20, 32'h0000_0002);
        rd(8'h20, "R9 clear then set");
        drain();
        check("R9 bit0 off", 64'(en_m[64]), 64'(0));

        // R2 / R7: walk one source per group with everything enabled
        for (int b = 0; b < NB; b++) wr(8'(b * 16), 32'hFFFF_FFFF);
        for (int g = 0; g < NG; g++) begin
            logic [NS-1:0] v;
            v = '0;
            v[g*8 + (g % 8)] = 1'b1;
            set_irq(v);
            check($sformatf("R2 R7 walk group %0d", g), 64'(grp_irq), 64'(1) << g);
        end
        drain();

        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R5: %0d reads never compared, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule